// File: doc/BRIEF.md
# Cipher byte staging buffer

This block sits between a byte-wide host port and a block cipher engine that works on 64-bit words. The host writes plaintext or ciphertext one byte at a time into an input holding word. When that word reaches the fill level the current chaining mode calls for, the block offers it to the engine over a valid/ready handshake. Results come back from the engine the same way. They are parked in an output holding word that the host drains one byte per read.

The fill level follows the 2-bit mode input. Codes 00 (codebook) and 01 (block chaining) work on whole 8-byte words. Codes 10 (8-bit feedback) and 11 (1-bit feedback) work on one byte at a time. In the byte modes the single byte travels in the most significant lane and the lower lanes are zero. A read of an empty output word does not drive the bus: the read-enable output stays low, and the pad driver tri-states on it. A change of mode throws away whatever is staged in both words.

Top module: `cipher_stage_buf`

## Requirements
- R1: After synchronous reset, both holding words are empty: in_empty=1, in_full=0, out_empty=1, out_full=0, eng_in_valid=0, rd_oe=0, and the latched mode is 00.
- R2: In modes 00 and 01, in_full rises after the eighth accepted write. The delivered block carries the first byte in bits 63:56 and each later byte in the next lower lane, so the eighth byte lands in bits 7:0.
- R3: In modes 10 and 11, in_full rises after a single accepted write. The delivered block carries that byte in bits 63:56 with bits 55:0 zero.
- R4: A write while in_full is high is dropped: the count and eng_in_data are unchanged.
- R5: eng_in_valid is high exactly while in_full is high and the mode is unchanged. In the cycle after a handshake (eng_in_valid and eng_in_ready both high), in_empty is high, whatever the engine is still doing.
- R6: eng_out_ready is high only while the output word is empty and the mode is unchanged. A result is taken only when eng_out_valid and eng_out_ready are both high.
- R7: A taken result yields 8 readable bytes in modes 00/01 and 1 byte (bits 63:56) in modes 10/11, read most significant lane first. A read of a non-empty word returns its byte on rd_data with rd_oe high in the following cycle.
- R8: out_full is high while at least one unread byte remains. out_empty rises only after the last byte has been read.
- R9: A read while the output word is empty leaves rd_oe low in the following cycle and changes no state.
- R10: When the mode input differs from the latched mode, the new mode is latched and both byte counts clear on that edge. Writes, reads and both handshakes are suppressed in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Chaining mode: 00 codebook, 01 block chaining, 10 8-bit feedback, 11 1-bit feedback |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host byte read strobe |
| rd_data | output | 8 | Host read byte, meaningful while rd_oe is high |
| rd_oe | output | 1 | Read bus output enable; low leaves the bus high-impedance |
| in_full | output | 1 | Input word has reached the mode's fill level |
| in_empty | output | 1 | Input word holds no bytes |
| out_full | output | 1 | Output word holds at least one unread byte |
| out_empty | output | 1 | Output word holds no unread byte |
| eng_in_valid | output | 1 | Block offered to the engine |
| eng_in_ready | input | 1 | Engine accepts the offered block |
| eng_in_data | output | 64 | Block offered to the engine |
| eng_out_valid | input | 1 | Engine result available |
| eng_out_ready | output | 1 | Buffer accepts the engine result |
| eng_out_data | input | 64 | Engine result block |

## Verification
A wrong byte count shows up at the flag ports on the very next edge. A lost or duplicated write appears at the latest as a wrong lane in eng_in_data when the block is offered. A mis-shifted output word shows in rd_data on the first read after the load. A stale count across a mode change shows as a flag that fails to fall one cycle after the change. A reference model built from byte queues is compared against every flag, the handshake outputs and the read bus on each cycle. Traffic mixes random writes, reads and engine stalls in all four modes, plus mode switches mid-stream.

// File: rtl/cstage_pkg.sv
package cstage_pkg;
  typedef enum logic [1:0] {
    CM_CODEBOOK  = 2'b00,
    CM_CHAIN     = 2'b01,
    CM_FEED_BYTE = 2'b10,
    CM_FEED_BIT  = 2'b11
  } chain_mode_e;

  // Byte-wide feedback modes have bit 1 set.
  function automatic logic is_byte_mode(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/cstage_mode_ctl.sv
module cstage_mode_ctl
  import cstage_pkg::*;
#(
  parameter int BYTES = 8,
  localparam int CNT_W = $clog2(BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  output logic [1:0]       mode_q,
  output logic             mode_chg,
  output logic [CNT_W-1:0] fill_lim
);
  always_ff @(posedge clk) begin
    if (rst) mode_q <= CM_CODEBOOK;
    else if (mode_chg) mode_q <= mode;
  end

  always_comb begin
    mode_chg = (mode != mode_q);
    fill_lim = is_byte_mode(mode_q) ? CNT_W'(1) : CNT_W'(BYTES);
  end
endmodule

// File: rtl/cstage_in_word.sv
module cstage_in_word #(
  parameter int BYTES  = 8,
  parameter int BYTE_W = 8,
  localparam int CNT_W  = $clog2(BYTES + 1),
  localparam int WORD_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [CNT_W-1:0]  lim,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic              empty,
  output logic [WORD_W-1:0] word
);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    full  = (cnt >= lim);
    empty = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      word <= '0;
    end else if (clr || take) begin
      cnt <= '0;
    end else if (wr_en && !full) begin
      cnt <= cnt + CNT_W'(1);
      for (int lane = 0; lane < BYTES; lane++) begin
        // lane 0 is the most significant byte
        if (lane == int'(cnt))
          word[(BYTES-1-lane)*BYTE_W +: BYTE_W] <= wr_data;
        else if (cnt == '0)
          word[(BYTES-1-lane)*BYTE_W +: BYTE_W] <= '0;
      end
    end
  end
endmodule

// File: rtl/cstage_out_word.sv
module cstage_out_word #(
  parameter int BYTES  = 8,
  parameter int BYTE_W = 8,
  localparam int CNT_W  = $clog2(BYTES + 1),
  localparam int WORD_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [CNT_W-1:0]  lim,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              rd_en,
  output logic              empty,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_oe
);
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] word;

  assign empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      word    <= '0;
      rd_data <= '0;
      rd_oe   <= 1'b0;
    end else if (clr) begin
      cnt   <= '0;
      rd_oe <= 1'b0;
    end else begin
      rd_oe <= 1'b0;
      if (load) begin
        word <= load_data;
        cnt  <= lim;
      end else if (rd_en && !empty) begin
        rd_data <= word[WORD_W-1 -: BYTE_W];
        word    <= word << BYTE_W;
        cnt     <= cnt - CNT_W'(1);
        rd_oe   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cipher_stage_buf.sv
module cipher_stage_buf #(
  parameter int BYTES  = 8,
  parameter int BYTE_W = 8,
  localparam int CNT_W  = $clog2(BYTES + 1),
  localparam int WORD_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              in_full,
  output logic              in_empty,
  output logic              out_full,
  output logic              out_empty,
  output logic              eng_in_valid,
  input  logic              eng_in_ready,
  output logic [WORD_W-1:0] eng_in_data,
  input  logic              eng_out_valid,
  output logic              eng_out_ready,
  input  logic [WORD_W-1:0] eng_out_data
);
  logic [1:0]       mode_q;
  logic             mode_chg;
  logic [CNT_W-1:0] fill_lim;
  logic             take, load;

  cstage_mode_ctl #(.BYTES(BYTES)) u_mode (
    .clk(clk), .rst(rst), .mode(mode),
    .mode_q(mode_q), .mode_chg(mode_chg), .fill_lim(fill_lim)
  );

  cstage_in_word #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_in (
    .clk(clk), .rst(rst), .clr(mode_chg), .lim(fill_lim),
    .wr_en(wr_en), .wr_data(wr_data), .take(take),
    .full(in_full), .empty(in_empty), .word(eng_in_data)
  );

  cstage_out_word #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst(rst), .clr(mode_chg), .lim(fill_lim),
    .load(load), .load_data(eng_out_data), .rd_en(rd_en),
    .empty(out_empty), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  always_comb begin
    out_full      = !out_empty;
    eng_in_valid  = in_full && !mode_chg;
    take          = eng_in_valid && eng_in_ready;
    eng_out_ready = out_empty && !mode_chg;
    load          = eng_out_valid && eng_out_ready;
  end
endmodule

// File: rtl/cstage_buf_chk.sv
module cstage_buf_chk #(
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_chg,
  input logic [1:0]        mode_q,
  input logic              wr_en,
  input logic              rd_en,
  input logic              rd_oe,
  input logic              in_full,
  input logic              in_empty,
  input logic              out_empty,
  input logic              eng_in_valid,
  input logic              eng_in_ready,
  input logic [WORD_W-1:0] eng_in_data,
  input logic              eng_out_valid,
  input logic              eng_out_ready
);
  assert_full_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (in_full && wr_en && !eng_in_ready && !mode_chg) |=> $stable(eng_in_data) && in_full);

  assert_byte_lanes_R3: assert property (@(posedge clk) disable iff (rst)
    (eng_in_valid && mode_q[1]) |-> (eng_in_data[WORD_W-9:0] == '0));

  assert_handoff_empty_R5: assert property (@(posedge clk) disable iff (rst)
    (eng_in_valid && eng_in_ready) |=> in_empty);

  assert_load_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (eng_out_valid && eng_out_ready) |-> out_empty);

  assert_oe_source_R7: assert property (@(posedge clk) disable iff (rst)
    rd_oe |-> $past(rd_en));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && out_empty) |=> !rd_oe);

  assert_mode_clear_R10: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (in_empty && out_empty && !rd_oe));
endmodule

bind cipher_stage_buf cstage_buf_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .mode_chg(mode_chg), .mode_q(mode_q),
  .wr_en(wr_en), .rd_en(rd_en), .rd_oe(rd_oe),
  .in_full(in_full), .in_empty(in_empty), .out_empty(out_empty),
  .eng_in_valid(eng_in_valid), .eng_in_ready(eng_in_ready),
  .eng_in_data(eng_in_data), .eng_out_valid(eng_out_valid),
  .eng_out_ready(eng_out_ready)
);

// File: tb/tb_cipher_stage_buf.sv
`timescale 1ns/1ps
module tb_cipher_stage_buf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic        rd_oe, in_full, in_empty, out_full, out_empty;
  logic        eng_in_valid, eng_in_ready, eng_out_valid, eng_out_ready;
  logic [63:0] eng_in_data, eng_out_data;

  always #2 clk = ~clk;

  cipher_stage_buf dut (
    .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_oe(rd_oe),
    .in_full(in_full), .in_empty(in_empty), .out_full(out_full), .out_empty(out_empty),
    .eng_in_valid(eng_in_valid), .eng_in_ready(eng_in_ready), .eng_in_data(eng_in_data),
    .eng_out_valid(eng_out_valid), .eng_out_ready(eng_out_ready), .eng_out_data(eng_out_data)
  );

  // stand-in engine: XOR with a constant after a few cycles
  logic       e_busy = 1'b0, e_stall = 1'b0, e_ov = 1'b0;
  logic [2:0] e_lat = 3'd0;
  logic [63:0] e_data = '0;
  assign eng_in_ready  = !e_busy && !e_stall;
  assign eng_out_valid = e_ov;
  assign eng_out_data  = e_data;

  always @(posedge clk) begin
    if (rst) begin
      e_busy <= 1'b0; e_ov <= 1'b0; e_lat <= 3'd0;
    end else if (!e_busy) begin
      if (eng_in_valid && eng_in_ready) begin
        e_busy <= 1'b1; e_lat <= 3'd3; e_data <= eng_in_data ^ 64'h5AC3_0F96_E17B_2D48;
      end
    end else if (!e_ov) begin
      if (e_lat == 3'd0) e_ov <= 1'b1; else e_lat <= e_lat - 3'd1;
    end else if (eng_out_ready) begin
      e_ov <= 1'b0; e_busy <= 1'b0;
    end
  end

  // reference model
  logic [7:0] m_inq[$];
  logic [7:0] m_outq[$];
  logic [1:0] m_mode;
  logic       m_oe;
  logic [7:0] m_rd;
  integer checks = 0, fails = 0;
  bit done = 0;

  function automatic int lim_of(input logic [1:0] m);
    return m[1] ? 1 : 8;
  endfunction

  function automatic logic [63:0] m_word();
    logic [63:0] w = '0;
    foreach (m_inq[i]) w[63-8*i -: 8] = m_inq[i];
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_inq.delete(); m_outq.delete(); m_mode = 2'b00; m_oe = 0; m_rd = 0;
    end else if (mode != m_mode) begin
      m_mode = mode; m_inq.delete(); m_outq.delete(); m_oe = 0;
    end else begin
      bit full_pre, oempty_pre;
      full_pre   = (m_inq.size() >= lim_of(m_mode));
      oempty_pre = (m_outq.size() == 0);
      m_oe = 0;
      if (full_pre && eng_in_ready) m_inq.delete();
      else if (wr_en && !full_pre) m_inq.push_back(wr_data);
      if (eng_out_valid && oempty_pre) begin
        for (int i = 0; i < lim_of(m_mode); i++) m_outq.push_back(eng_out_data[63-8*i -: 8]);
      end else if (rd_en && !oempty_pre) begin
        m_rd = m_outq.pop_front(); m_oe = 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit mf, ms;
    mf = (m_inq.size() >= lim_of(m_mode));
    ms = (mode == m_mode);
    chk("R2 R3 in_full",  in_full,  mf);
    chk("R5 in_empty",    in_empty, m_inq.size() == 0);
    chk("R5 eng_in_valid", eng_in_valid, mf && ms);
    if (mf) chk("R2 R3 R4 eng_in_data", eng_in_data, m_word());
    chk("R8 out_full",    out_full,  m_outq.size() != 0);
    chk("R8 out_empty",   out_empty, m_outq.size() == 0);
    chk("R6 eng_out_ready", eng_out_ready, (m_outq.size() == 0) && ms);
    chk("R9 R7 rd_oe",    rd_oe, m_oe);
    if (m_oe) chk("R7 rd_data", rd_data, m_rd);
  endtask

  task automatic step(input int wp, input int rp, input int sp);
    @(negedge clk);
    compare_all();
    wr_en   = ($urandom_range(99) < wp);
    wr_data = 8'($urandom);
    rd_en   = ($urandom_range(99) < rp);
    e_stall = ($urandom_range(99) < sp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 in_empty", in_empty, 1); chk("R1 in_full", in_full, 0);
    chk("R1 out_empty", out_empty, 1); chk("R1 out_full", out_full, 0);
    chk("R1 eng_in_valid", eng_in_valid, 0); chk("R1 rd_oe", rd_oe, 0);

    // R2 directed fill in codebook mode with engine stalled, then R4 overfill
    e_stall = 1'b1;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); compare_all();
      wr_en = 1; wr_data = 8'h10 + 8'(i);
    end
    @(negedge clk); compare_all();
    chk("R2 first byte in top lane", eng_in_data[63:56], 8'h10);
    chk("R4 overflow dropped", eng_in_data[7:0], 8'h17);
    wr_en = 0;
    // R9 read while empty
    rd_en = 1;
    @(negedge clk); compare_all();
    @(negedge clk); compare_all();
    chk("R9 rd_oe low on empty read", rd_oe, 0);
    rd_en = 0; e_stall = 0;
    // R5 handoff, then drain (R7, R8)
    for (int i = 0; i < 20; i++) step(0, 100, 0);

    // random traffic in every mode
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); compare_all(); mode = 2'(m);
      for (int i = 0; i < 600; i++) step(50, 50, 30);
    end
    // R3 directed: byte mode single write
    @(negedge clk); compare_all(); mode = 2'b10; wr_en = 0; rd_en = 0; e_stall = 1;
    for (int i = 0; i < 12; i++) begin @(negedge clk); compare_all(); end
    @(negedge clk); compare_all(); wr_en = 1; wr_data = 8'hC7;
    @(negedge clk); compare_all(); wr_en = 0;
    @(negedge clk); compare_all();
    chk("R3 single byte fills", in_full, 1);
    chk("R3 block layout", eng_in_data, 64'hC700_0000_0000_0000);
    // R10 mode change mid-stream clears counts
    mode = 2'b01;
    @(negedge clk); compare_all();
    chk("R10 in_empty after change", in_empty, 1);
    chk("R10 out_empty after change", out_empty, 1);
    e_stall = 0;
    for (int i = 0; i < 1500; i++) begin
      if (i % 97 == 50) begin @(negedge clk); compare_all(); mode = 2'($urandom); end
      else step(60, 40, 20);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule